// File: doc/BRIEF.md
# Indirect Register Access Bridge

A host reaches a 4 KB target register space through a window of four 32-bit registers. It loads a target address and, for a write, the write data. It then writes a command word that asks for one read or one write. The bridge runs exactly one transaction on a request/acknowledge target bus whose response latency varies. When the transaction ends, it sets an acknowledge flag inside the command word. For a read, the returned value is available in the read-data register. The host then writes an all-zero word to the command register. It waits until the command register reads back zero before it starts the next access.

The bridge always finishes within a bounded time, so a host that polls with a timeout never waits in vain. A target that does not answer within `TIMEOUT` cycles is abandoned, and the bridge acknowledges the command anyway. An address the target cannot hold is refused without any bus activity. A clear command brings the bridge back to idle from any state, including during a transaction, so a host that finds a leftover command can always recover.

Top module: `ind_reg_bridge`

## Requirements
- R1: After a synchronous active-high reset, all four window registers read 0 and `t_req` is low.
- R2: The host selects the window register with `h_word`: 0 is command, 1 is target address, 2 is read data, 3 is write data. The address and write-data registers read back the last value written to them while the bridge is not busy.
- R3: Writing command 0x2 (bit 1 set, write) in idle performs one target write of the latched write data to the latched address with `t_we` high. The command register then reads 0x6, with bit 2 as the acknowledge flag.
- R4: Writing command 0x1 (bit 0 set, read) in idle performs one target read with `t_we` low. The command register then reads 0x5, and the read-data register holds the value the target returned.
- R5: Writing the all-zero word to the command register returns the bridge to idle from any state, including during a transaction. It drops `t_req` on the next cycle, the command register reads exactly 0, and a later command is accepted normally.
- R6: While a transaction is in flight, writes to the command, address and write-data registers are ignored. While the acknowledge flag is set, non-zero command writes are ignored.
- R7: A non-zero command word whose bits 1:0 are not exactly one of 01 or 10 is ignored. It starts no target access, and the command register stays 0 with no acknowledge.
- R8: A command with a target address above 0xFFF or not a multiple of 4 causes no target access and is acknowledged on the cycle after the command write. A read of such an address loads 0xFFFFFFFF into the read-data register.
- R9: The read-data register keeps its value until the next read completes. Write transactions and clears leave it unchanged.
- R10: If the target does not acknowledge within `TIMEOUT` cycles, the bridge drops `t_req` and sets the acknowledge flag. For a read, it loads 0xFFFFFFFF.
- R11: While `t_req` is high, `t_addr`, `t_we` and `t_wdata` are held stable. A single-cycle `t_ack` ends the request on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe for the selected window register |
| h_word | input | 2 | Window register index (0 command, 1 address, 2 read data, 3 write data) |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Selected window register, combinational |
| t_req | output | 1 | Target request, held until acknowledge, timeout or clear |
| t_we | output | 1 | Target direction, 1 for write |
| t_addr | output | AW | Target byte address |
| t_wdata | output | DW | Target write data |
| t_ack | input | 1 | Target acknowledge, one cycle |
| t_rdata | input | DW | Target read data, valid with `t_ack` |

## Verification
The hardest situations to reach are the ones where the target stays silent or answers late. Examples are a clear command issued in the middle of a transaction, and commands or address writes that arrive while a request is outstanding. The bench's target model has a latency that the bench can set and an enable switch that the bench can turn off. With a long latency, the bench can act during the open request and then check `t_addr`, `t_we` and the window readback. With the target switched off, the bench measures how many polls pass before the acknowledge flag appears in the timeout case.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] ADDR_MAX = 'hFFF,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr_en,
  input  logic [1:0]    h_word,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          t_req,
  output logic          t_we,
  output logic [AW-1:0] t_addr,
  output logic [DW-1:0] t_wdata,
  input  logic          t_ack,
  input  logic [DW-1:0] t_rdata
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] W_CMD = 2'd0, W_ADDR = 2'd1, W_RDAT = 2'd2, W_WDAT = 2'd3;

  logic [1:0]    cmd_q;
  logic          ack_q, busy_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;
  logic [TW-1:0] tcnt;

  wire sel_cmd  = h_wr_en && h_word == W_CMD;
  wire clr      = sel_cmd && h_wdata == '0;
  wire idle     = !busy_q && !ack_q;
  wire start    = sel_cmd && idle && ^h_wdata[1:0];
  wire addr_bad = addr_q > ADDR_MAX || addr_q[1:0] != 2'b00;
  wire expire   = tcnt == TW'(TIMEOUT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      tcnt   <= '0;
    end else begin
      if (h_wr_en && h_word == W_ADDR && !busy_q) addr_q <= h_wdata[AW-1:0];
      if (h_wr_en && h_word == W_WDAT && !busy_q) wdat_q <= h_wdata;
      if (clr) begin
        cmd_q  <= '0;
        ack_q  <= 1'b0;
        busy_q <= 1'b0;
        tcnt   <= '0;
      end else if (start) begin
        cmd_q <= h_wdata[1:0];
        tcnt  <= '0;
        if (addr_bad) begin
          ack_q <= 1'b1;
          if (h_wdata[0]) rdat_q <= '1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (t_ack) begin
          busy_q <= 1'b0;
          ack_q  <= 1'b1;
          if (cmd_q[0]) rdat_q <= t_rdata;
        end else if (expire) begin
          busy_q <= 1'b0;
          ack_q  <= 1'b1;
          if (cmd_q[0]) rdat_q <= '1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign t_req   = busy_q;
  assign t_we    = cmd_q[1];
  assign t_addr  = addr_q;
  assign t_wdata = wdat_q;

  always_comb begin
    case (h_word)
      W_CMD:   h_rdata = DW'({ack_q, cmd_q});
      W_ADDR:  h_rdata = DW'(addr_q);
      W_RDAT:  h_rdata = rdat_q;
      default: h_rdata = wdat_q;
    endcase
  end
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] ADDR_MAX = 'hFFF,
  parameter int TIMEOUT = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          h_wr_en,
  input logic [1:0]    h_word,
  input logic [DW-1:0] h_wdata,
  input logic          t_req,
  input logic          t_we,
  input logic [AW-1:0] t_addr,
  input logic          t_ack,
  input logic          ack_q,
  input logic          busy_q
);
  wire clr_wr  = h_wr_en && h_word == 2'd0 && h_wdata == '0;
  wire cmd_nz  = h_wr_en && h_word == 2'd0 && h_wdata != '0 && !busy_q && !ack_q;
  wire bad_adr = t_addr > ADDR_MAX || t_addr[1:0] != 2'b00;
  int unsigned req_run;

  always_ff @(posedge clk) begin
    if (rst || !t_req) req_run <= 0;
    else req_run <= req_run + 1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !t_req && !ack_q);
  a_r5_clear_idles: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !t_req && !ack_q);
  a_r7_noop_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_nz && !(^h_wdata[1:0])) |=> !t_req && !ack_q);
  a_r8_bad_addr_no_access: assert property (@(posedge clk) disable iff (rst)
    (cmd_nz && ^h_wdata[1:0] && bad_adr) |=> ack_q && !t_req);
  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    (t_req && !t_ack && !clr_wr) |=> (t_req || ack_q));
  a_r11_target_stable: assert property (@(posedge clk) disable iff (rst)
    (t_req && $past(t_req)) |-> ($stable(t_addr) && $stable(t_we)));
  a_r11_ack_ends_req: assert property (@(posedge clk) disable iff (rst)
    (t_req && t_ack) |=> !t_req);
  a_r10_bounded_wait: assert property (@(posedge clk) disable iff (rst)
    req_run <= TIMEOUT);
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(
  .AW(AW), .DW(DW), .ADDR_MAX(ADDR_MAX), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_word(h_word), .h_wdata(h_wdata),
  .t_req(t_req), .t_we(t_we), .t_addr(t_addr), .t_ack(t_ack),
  .ack_q(ack_q), .busy_q(busy_q)
);

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
  localparam int TMO = 64;
  logic clk = 1'b0, rst = 1'b1;
  logic h_wr_en = 1'b0;
  logic [1:0] h_word = 2'd0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic t_req, t_we, t_ack = 1'b0;
  logic [31:0] t_addr, t_wdata, t_rdata = '0;

  ind_reg_bridge #(.TIMEOUT(TMO)) u_ind_reg_bridge (
    .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_word(h_word), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .t_req(t_req), .t_we(t_we), .t_addr(t_addr),
    .t_wdata(t_wdata), .t_ack(t_ack), .t_rdata(t_rdata)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, lat = 3, acc = 0, tcnt = 0;
  bit tgt_on = 1'b1, done = 1'b0;
  logic [31:0] mem [0:1023];

  always @(posedge clk) begin
    t_ack <= 1'b0;
    if (rst || !t_req || t_ack || !tgt_on) tcnt <= 0;
    else if (tcnt == lat) begin
      t_ack <= 1'b1;
      tcnt <= 0;
      acc <= acc + 1;
      if (t_we) mem[t_addr[11:2]] <= t_wdata;
      else t_rdata <= mem[t_addr[11:2]];
    end else tcnt <= tcnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    h_wr_en = 1'b1; h_word = w; h_wdata = d;
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] w, output logic [31:0] d);
    h_word = w;
    #1;
    d = h_rdata;
  endtask

  task automatic wait_ack(input int max, output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      host_rd(2'd0, v);
      if (v[2] || n > max) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      host_rd(2'(i), v);
      check(v == 0, "R1 register after reset", v, 0);
    end
    check(t_req == 1'b0, "R1 t_req after reset", 32'(t_req), 0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    host_wr(2'd1, 32'h10);
    host_wr(2'd3, 32'hCAFE0001);
    host_rd(2'd1, v); check(v == 32'h10, "R2 address readback", v, 32'h10);
    host_rd(2'd3, v); check(v == 32'hCAFE0001, "R2 write data readback", v, 32'hCAFE0001);
  endtask

  task automatic t_write();
    logic [31:0] v; int n, a0;
    lat = 3; a0 = acc;
    host_wr(2'd3, 32'hA5A50001);
    host_wr(2'd1, 32'h40);
    host_wr(2'd0, 32'h2);
    check(t_req && t_we, "R3 write request issued", {30'd0, t_req, t_we}, 3);
    wait_ack(TMO + 4, n);
    host_rd(2'd0, v); check(v == 32'h6, "R3 command after write", v, 32'h6);
    check(mem[16] == 32'hA5A50001, "R3 target got data", mem[16], 32'hA5A50001);
    check(acc == a0 + 1, "R3 single access", acc, a0 + 1);
    host_wr(2'd0, 32'h0);
    host_rd(2'd0, v); check(v == 0, "R5 clear after write", v, 0);
  endtask

  task automatic t_read();
    logic [31:0] v; int n;
    host_wr(2'd1, 32'h40);
    host_wr(2'd0, 32'h1);
    check(t_req && !t_we, "R4 read request issued", {30'd0, t_req, t_we}, 2);
    wait_ack(TMO + 4, n);
    host_rd(2'd0, v); check(v == 32'h5, "R4 command after read", v, 32'h5);
    host_rd(2'd2, v); check(v == 32'hA5A50001, "R4 read data", v, 32'hA5A50001);
    host_wr(2'd0, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v; int n;
    host_wr(2'd3, 32'h12345678);
    host_wr(2'd1, 32'h80);
    host_wr(2'd0, 32'h2);
    wait_ack(TMO + 4, n);
    host_wr(2'd0, 32'h0);
    host_rd(2'd2, v); check(v == 32'hA5A50001, "R9 read data held over write", v, 32'hA5A50001);
  endtask

  task automatic t_busy();
    logic [31:0] v; int n;
    lat = 20;
    host_wr(2'd1, 32'h80);
    host_wr(2'd0, 32'h1);
    host_wr(2'd0, 32'h2);
    host_wr(2'd1, 32'h100);
    host_wr(2'd3, 32'h0BAD0BAD);
    check(t_req == 1'b1, "R11 request held", 32'(t_req), 1);
    check(t_addr == 32'h80 && !t_we, "R6 target address kept while busy", t_addr, 32'h80);
    host_rd(2'd1, v); check(v == 32'h80, "R6 address write ignored while busy", v, 32'h80);
    host_rd(2'd3, v); check(v == 32'h12345678, "R6 data write ignored while busy", v, 32'h12345678);
    wait_ack(TMO + 4, n);
    host_rd(2'd0, v); check(v == 32'h5, "R6 command write ignored while busy", v, 32'h5);
    host_rd(2'd2, v); check(v == 32'h12345678, "R4 read of written word", v, 32'h12345678);
    host_wr(2'd0, 32'h2);
    host_rd(2'd0, v); check(v == 32'h5 && !t_req, "R6 command ignored while acknowledged", v, 32'h5);
    host_wr(2'd0, 32'h0);
    lat = 3;
  endtask

  task automatic t_noop();
    logic [31:0] v; int a0;
    a0 = acc;
    host_wr(2'd0, 32'h3);
    repeat (5) @(negedge clk);
    host_rd(2'd0, v); check(v == 0 && !t_req, "R7 both bits set ignored", v, 0);
    host_wr(2'd0, 32'h4);
    repeat (5) @(negedge clk);
    host_rd(2'd0, v); check(v == 0 && !t_req, "R7 ack-only word ignored", v, 0);
    check(acc == a0, "R7 no target access", acc, a0);
  endtask

  task automatic t_badaddr();
    logic [31:0] v; int a0, n;
    a0 = acc;
    host_wr(2'd1, 32'h1000);
    host_wr(2'd0, 32'h1);
    host_rd(2'd0, v); check(v == 32'h5 && !t_req, "R8 above range acknowledged at once", v, 32'h5);
    host_rd(2'd2, v); check(v == 32'hFFFFFFFF, "R8 read of bad address", v, 32'hFFFFFFFF);
    host_wr(2'd0, 32'h0);
    host_wr(2'd1, 32'h6);
    host_wr(2'd0, 32'h2);
    host_rd(2'd0, v); check(v == 32'h6 && !t_req, "R8 unaligned acknowledged at once", v, 32'h6);
    repeat (8) @(negedge clk);
    check(acc == a0, "R8 no target access", acc, a0);
    host_wr(2'd0, 32'h0);
    host_wr(2'd1, 32'hFFC);
    host_wr(2'd0, 32'h2);
    wait_ack(TMO + 4, n);
    check(acc == a0 + 1, "R8 top address 0xFFC accessed", acc, a0 + 1);
    host_wr(2'd0, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] v; int n;
    tgt_on = 1'b0;
    host_wr(2'd1, 32'h20);
    host_wr(2'd0, 32'h1);
    wait_ack(TMO + 8, n);
    check(n >= TMO - 2 && n <= TMO + 2, "R10 acknowledge after timeout", n, TMO);
    check(t_req == 1'b0, "R10 request dropped", 32'(t_req), 0);
    host_rd(2'd2, v); check(v == 32'hFFFFFFFF, "R10 read data on timeout", v, 32'hFFFFFFFF);
    host_wr(2'd0, 32'h0);
    tgt_on = 1'b1;
  endtask

  task automatic t_clear_busy();
    logic [31:0] v; int n;
    lat = 30;
    host_wr(2'd1, 32'h40);
    host_wr(2'd0, 32'h1);
    repeat (3) @(negedge clk);
    host_wr(2'd0, 32'h0);
    host_rd(2'd0, v); check(v == 0 && !t_req, "R5 clear during transaction", v, 0);
    repeat (40) @(negedge clk);
    host_rd(2'd0, v); check(v == 0, "R5 stays idle after clear", v, 0);
    lat = 2;
    host_wr(2'd0, 32'h1);
    wait_ack(TMO + 4, n);
    host_rd(2'd0, v); check(v == 32'h5, "R5 command accepted after clear", v, 32'h5);
    host_wr(2'd0, 32'h0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_window();
    t_write();
    t_read();
    t_hold();
    t_busy();
    t_noop();
    t_badaddr();
    t_timeout();
    t_clear_busy();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end
endmodule